// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block is a 16-bit counter fed from a single asynchronous input pin. It has two modes. In event mode it adds one for each input edge of the selected polarity. In gated mode it adds one for each tick of a divide-by-64 copy of the bus clock, but only while the input sits at its selected active level. In gated mode the count is therefore a measure of how long the input was active, in units of 64 bus clocks.

Software can load the counter at any time. When the counter wraps from its top value to zero, a sticky overflow flag is set. Software clears the flag by writing a one to it. An interrupt request is raised while the flag is set and the interrupt enable is on. The counter never clears itself: it only moves by counting or by a software load.

Top module: `pulse_accum`

## Requirements
- R1: After reset, `cnt_q` is 0x0000 and both `ovf_flag` and `irq` are 0.
- R2: With `acc_en`=1, `mode_gated`=0 and `edge_sel`=1, each rising edge of `pin_in` adds exactly one to `cnt_q`.
- R3: With `acc_en`=1, `mode_gated`=0 and `edge_sel`=0, each falling edge of `pin_in` adds exactly one to `cnt_q`, and rising edges add nothing.
- R4: An input level that is held for at least three bus clocks between edges is counted exactly once. The counter changes on the third rising clock edge after the pin changes, because of the two-stage synchronizer.
- R5: With `acc_en`=1, `mode_gated`=1 and `edge_sel`=0, `cnt_q` gains exactly one every 64 bus clocks while the synchronized input is high. It does not change while the input is low.
- R6: With `mode_gated`=1 and `edge_sel`=1, the active gate level is low: `cnt_q` gains exactly one every 64 bus clocks while the input is low.
- R7: While `acc_en`=0, neither input edges nor prescaler ticks change `cnt_q`, and the divide-by-64 prescaler keeps its phase.
- R8: An increment taken at 0xFFFF wraps `cnt_q` to 0x0000 and sets `ovf_flag`.
- R9: `irq` is 1 exactly when `ovf_flag`=1 and `ovf_ie`=1.
- R10: A cycle with `ovf_clr`=1 clears `ovf_flag`. If a wrap happens in the same cycle, the flag is set instead.
- R11: A cycle with `cnt_wr`=1 loads `cnt_wdata` into `cnt_q` on the next clock edge. The load overrides any increment in that cycle and never sets `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Asynchronous accumulator input |
| acc_en | input | 1 | Accumulator enable |
| mode_gated | input | 1 | 0 = event counting, 1 = gated time accumulation |
| edge_sel | input | 1 | Event: 0 falling, 1 rising. Gated: 0 counts while high, 1 counts while low |
| ovf_ie | input | 1 | Overflow interrupt enable |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | 16 | Counter load value |
| ovf_clr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| cnt_q | output | 16 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a divide-by-64 prescaler and two synchronizer stages. Software loads near 0xFFFF let a few events reach the wrap, the flag and the interrupt gating. With the 64-cycle prescaler, runs of a few hundred cycles in gated mode yield exact tick counts for both gate polarities. A load held across prescaler ticks exercises the rule that a load beats an increment.

// File: rtl/pa_pkg.sv
// Shared types for the pulse accumulator.
// Assumes: nothing beyond standard SystemVerilog.
package pa_pkg;
    typedef enum logic {
        PA_EVENT = 1'b0,
        PA_GATED = 1'b1
    } pa_mode_e;
endpackage

// File: rtl/pa_input_sync.sv
// Brings the asynchronous pin into the clock domain and detects edges on the
// synchronized value.
// Assumes: the pin holds each level for longer than STAGES clocks.
module pa_input_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int TAPS = STAGES + 1;

    logic [TAPS-1:0] shreg;

    // Shift the pin through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[TAPS-2:0], pin};
    end

    // Decode level and edges from the last synchronized stage and its history.
    always_comb begin
        level = shreg[STAGES-1];
        rise  = shreg[STAGES-1] & ~shreg[STAGES];
        fall  = ~shreg[STAGES-1] & shreg[STAGES];
    end
endmodule

// File: rtl/pa_prescaler.sv
// Free-running clock divider that gives a one-cycle tick every DIV enabled
// cycles. It holds its phase while disabled.
// Assumes: DIV >= 2.
module pa_prescaler #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    // Tick on the last phase of each period while enabled.
    assign tick = en && (phase == LAST);

    // Advance the phase when enabled and wrap after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase <= '0;
        else if (tick) phase <= '0;
        else if (en)   phase <= phase + 1'b1;
    end
endmodule

// File: rtl/pa_counter.sv
// Counter with a software load, a sticky overflow flag and a
// write-one-to-clear input.
// Assumes: inc is a single-cycle strobe. A load wins over inc.
module pa_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         flag
);
    logic wrap;

    // A wrap happens only on an increment at the top value that no load overrides.
    assign wrap = inc && !wr && (&cnt);

    // Load first, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (wr)  cnt <= wdata;
        else if (inc) cnt <= cnt + 1'b1;
    end

    // Sticky flag: a wrap sets it and wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (wrap) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end
endmodule

// File: rtl/pulse_accum.sv
// Dual-mode pulse accumulator: counts input edges, or counts divided-clock
// ticks while the input is active. Raises a gated overflow interrupt.
// Assumes: control inputs are synchronous to clk. Only pin_in is asynchronous.
module pulse_accum
    import pa_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PRESC_DIV   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic             acc_en,
    input  logic             mode_gated,
    input  logic             edge_sel,
    input  logic             ovf_ie,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_flag,
    output logic             irq
);
    pa_mode_e mode;
    logic     lvl, rise, fall, tick;
    logic     gate_on, edge_hit, inc;

    pa_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(pin_in),
        .level(lvl), .rise(rise), .fall(fall)
    );

    pa_prescaler #(.DIV(PRESC_DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .en(acc_en), .tick(tick)
    );

    // Pick the increment source from the mode and the polarity select.
    always_comb begin
        mode     = pa_mode_e'(mode_gated);
        gate_on  = edge_sel ? ~lvl : lvl;
        edge_hit = edge_sel ? rise : fall;
        inc      = acc_en && ((mode == PA_GATED) ? (tick && gate_on) : edge_hit);
    end

    pa_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(inc), .wr(cnt_wr), .wdata(cnt_wdata),
        .clr(ovf_clr), .cnt(cnt_q), .flag(ovf_flag)
    );

    // Interrupt request only while the flag is enabled.
    assign irq = ovf_flag & ovf_ie;
endmodule

// File: rtl/pulse_accum_checker.sv
// Temporal checks on the pulse accumulator ports, bound to every instance.
// Assumes: synchronous active-low reset.
module pulse_accum_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_en,
    input logic             ovf_ie,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic             ovf_clr,
    input logic [CNT_W-1:0] cnt_q,
    input logic             ovf_flag,
    input logic             irq
);
    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

    a_r7_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !cnt_wr) |=> $stable(cnt_q));

    a_r8_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == '1) && !cnt_wr) ##1 (cnt_q == '0) |-> ovf_flag);

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_ie |-> !irq);

    a_r10_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && (cnt_q != '1)) |=> !ovf_flag);

    a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(cnt_wdata)));
endmodule

bind pulse_accum pulse_accum_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .ovf_ie(ovf_ie),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .ovf_clr(ovf_clr),
    .cnt_q(cnt_q), .ovf_flag(ovf_flag), .irq(irq)
);

// File: tb/sim_pulse_accum.sv
module sim_pulse_accum;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0, acc_en = 1'b0, mode_gated = 1'b0, edge_sel = 1'b0;
    logic        ovf_ie = 1'b0, cnt_wr = 1'b0, ovf_clr = 1'b0;
    logic [15:0] cnt_wdata = '0;
    logic [15:0] cnt_q;
    logic        ovf_flag, irq;

    int    vectors = 0, fails = 0;
    string cur_req = "R1";
    bit    live = 1'b0;

    // Reference model state.
    int m_cnt = 0, m_presc = 0;
    bit m_flag = 1'b0;
    bit hist[$] = '{1'b0, 1'b0, 1'b0, 1'b0};

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_accum u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .acc_en(acc_en),
        .mode_gated(mode_gated), .edge_sel(edge_sel), .ovf_ie(ovf_ie),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .ovf_clr(ovf_clr),
        .cnt_q(cnt_q), .ovf_flag(ovf_flag), .irq(irq)
    );

    // Behavioural model: the pin is seen two clocks late and is counted per the mode.
    always @(posedge clk) begin
        bit now_lvl, old_lvl, tick, hit, wrapped;
        if (!rst_n) begin
            m_cnt = 0; m_presc = 0; m_flag = 1'b0;
            hist = '{1'b0, 1'b0, 1'b0, 1'b0};
        end else begin
            hist.push_front(pin_in);
            void'(hist.pop_back());
            now_lvl = hist[2];
            old_lvl = hist[3];
            tick = 1'b0;
            if (acc_en) begin
                tick = (m_presc == 63);
                m_presc = (m_presc + 1) % 64;
            end
            if (mode_gated) hit = tick && (edge_sel ? !now_lvl : now_lvl);
            else            hit = edge_sel ? (now_lvl && !old_lvl) : (!now_lvl && old_lvl);
            hit = hit && acc_en;
            wrapped = 1'b0;
            if (cnt_wr) m_cnt = cnt_wdata;
            else if (hit) begin
                if (m_cnt == 65535) begin m_cnt = 0; wrapped = 1'b1; end
                else m_cnt = m_cnt + 1;
            end
            if (wrapped) m_flag = 1'b1;
            else if (ovf_clr) m_flag = 1'b0;
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (live) begin
            vectors++;
            if (cnt_q !== 16'(m_cnt) || ovf_flag !== m_flag || irq !== (m_flag && ovf_ie)) begin
                fails++;
                $display("FAIL %s per-cycle: actual cnt=%h flag=%b irq=%b expected cnt=%h flag=%b irq=%b",
                         cur_req, cnt_q, ovf_flag, irq, 16'(m_cnt), m_flag, m_flag && ovf_ie);
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int hi, input int lo);
        pin_in = 1'b1; cycles(hi);
        pin_in = 1'b0; cycles(lo);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * WD_CYCLES);
        fails++;
        $display("FAIL watchdog (all R): actual=timeout expected=completion");
        summary();
    end

    initial begin
        int base;
        cycles(3);
        rst_n = 1'b1;
        live = 1'b1;
        cycles(1);
        // R1: reset state
        chk("R1 cnt", cnt_q, 0);
        chk("R1 flag", ovf_flag, 0);
        chk("R1 irq", irq, 0);

        // R2: rising edges in event mode
        cur_req = "R2";
        acc_en = 1'b1; mode_gated = 1'b0; edge_sel = 1'b1;
        repeat (5) pulse(3, 3);
        cycles(4);
        chk("R2 five rising edges", cnt_q, 5);

        // R3: falling edges only
        cur_req = "R3";
        edge_sel = 1'b0;
        base = cnt_q;
        repeat (4) pulse(4, 3);
        pin_in = 1'b1; cycles(5);
        chk("R3 rising edge ignored", cnt_q, base + 4);
        pin_in = 1'b0; cycles(4);
        chk("R3 four plus one falling", cnt_q, base + 5);

        // R4: latency of the synchronizer
        cur_req = "R4";
        edge_sel = 1'b1;
        base = cnt_q;
        pin_in = 1'b1;
        cycles(2);
        chk("R4 not yet counted", cnt_q, base);
        cycles(1);
        chk("R4 counted on third edge", cnt_q, base + 1);
        pin_in = 1'b0; cycles(4);

        // R7: disabled, edges ignored
        cur_req = "R7";
        acc_en = 1'b0;
        base = cnt_q;
        repeat (3) pulse(3, 3);
        cycles(4);
        chk("R7 edges ignored while disabled", cnt_q, base);

        // R5: gated, active high
        cur_req = "R5";
        acc_en = 1'b1; mode_gated = 1'b1; edge_sel = 1'b0;
        pin_in = 1'b1; cycles(3);
        base = cnt_q;
        cycles(320);
        chk("R5 five ticks while high", cnt_q, base + 5);
        pin_in = 1'b0; cycles(3);
        base = cnt_q;
        cycles(200);
        chk("R5 no ticks while low", cnt_q, base);

        // R7: disabled in gated mode, prescaler phase held (model compare)
        cur_req = "R7";
        acc_en = 1'b0; edge_sel = 1'b1;
        base = cnt_q;
        cycles(150);
        chk("R7 gated hold", cnt_q, base);

        // R6: gated, active low
        cur_req = "R6";
        acc_en = 1'b1;
        base = cnt_q;
        cycles(256);
        chk("R6 four ticks while low", cnt_q, base + 4);

        // R11: a held load beats the ticks
        cur_req = "R11";
        cnt_wr = 1'b1; cnt_wdata = 16'h1234;
        cycles(130);
        chk("R11 load wins over ticks", cnt_q, 16'h1234);
        cnt_wdata = 16'hFFFF; cycles(1);
        cnt_wdata = 16'h0000; cycles(1);
        cnt_wr = 1'b0; cycles(1);
        chk("R11 load through top value sets no flag", ovf_flag, 0);

        // R8, R9: wrap in event mode
        cur_req = "R8";
        mode_gated = 1'b0; edge_sel = 1'b1;
        cnt_wr = 1'b1; cnt_wdata = 16'hFFFD; cycles(1);
        cnt_wr = 1'b0; cycles(1);
        chk("R11 load value", cnt_q, 16'hFFFD);
        repeat (3) pulse(3, 3);
        cycles(4);
        chk("R8 wrapped to zero", cnt_q, 0);
        chk("R8 flag set", ovf_flag, 1);
        cur_req = "R9";
        chk("R9 irq masked", irq, 0);
        ovf_ie = 1'b1; cycles(1);
        chk("R9 irq raised", irq, 1);

        // R10: write-one-to-clear
        cur_req = "R10";
        ovf_clr = 1'b1; cycles(1);
        ovf_clr = 1'b0; cycles(1);
        chk("R10 flag cleared", ovf_flag, 0);
        chk("R10 irq dropped", irq, 0);

        // R10: set wins over clear (gated, clear held across a wrap)
        mode_gated = 1'b1; edge_sel = 1'b0; pin_in = 1'b1;
        cnt_wr = 1'b1; cnt_wdata = 16'hFFFF; cycles(1);
        cnt_wr = 1'b0;
        ovf_clr = 1'b1;
        cycles(70);
        ovf_clr = 1'b0;
        cycles(2);
        pin_in = 1'b0;
        cycles(4);

        live = 1'b0;
        summary();
    end
endmodule